// File: doc/BRIEF.md
# Low-Latency DRAM Command Front End

This block is the device-side command front end of an eight-bank, low-latency DDR DRAM. On every rising edge of the command clock it samples an active-low chip select, two active-low command strobes (write and refresh), a 21-bit address and a 3-bit bank address. It decodes the sample into one of four commands (read, write, auto refresh or mode-register set) and presents it to the rest of the device. Each command appears as a one-cycle strobe together with the bank and address it carried.

A mode-register-set command takes the address bus as configuration data instead of an address. The mode register holds the burst length (2, 4 or 8 beats), a 3-bit read-latency configuration code, the output impedance-match enable and the on-die-termination enable. These fields drive the downstream data path continuously. Data capture, the array, clock alignment and analog I/O are handled elsewhere.

Top module: `lldram_cmd_frontend`

## Requirements
- R1: While reset is asserted and after it is released, all command strobes are low, the bank and address outputs are 0, burst length is 2, the read-latency code is 0, and termination and impedance matching are off.
- R2: A sample with chip select high produces no strobe, leaves the bank and address outputs unchanged and leaves the mode register unchanged, whatever the other inputs are.
- R3: With chip select low, the strobes decode as follows: write high and refresh high gives read; write low and refresh high gives write; write high and refresh low gives auto refresh; both low gives mode-register set. Exactly one strobe rises, in the cycle after the sampling edge.
- R4: For every decoded command, the bank and address outputs show the bank and address sampled with it from the cycle after the sampling edge, and they hold until the next decoded command.
- R5: On a mode-register set, address bits 1:0 select the burst length: 00 gives 2 beats, 01 gives 4 and 10 gives 8. The burst-length output is the number of beats as a 4-bit value.
- R6: A mode-register set whose address bits 1:0 are 11 leaves the burst length at its previous value while still updating the other mode fields.
- R7: On a mode-register set, address bits 4:2 become the read-latency configuration code.
- R8: On a mode-register set, address bit 8 becomes the impedance-match enable and address bit 9 becomes the termination enable.
- R9: The mode fields change only on a mode-register set. Read, write, auto refresh and deselected cycles leave them unchanged. New values appear in the cycle after the sampling edge.
- R10: A strobe lasts exactly one cycle. It falls after one cycle unless the next sample decodes to the same command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Command clock; inputs sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write command strobe, active low |
| ref_ni | input | 1 | Refresh command strobe, active low |
| addr_i | input | 21 | Address, or mode data during a mode-register set |
| bank_i | input | 3 | Bank address |
| rd_o | output | 1 | Read command strobe |
| wr_o | output | 1 | Write command strobe |
| aref_o | output | 1 | Auto refresh command strobe |
| mrs_o | output | 1 | Mode-register-set strobe |
| bank_o | output | 3 | Bank of the last decoded command |
| addr_o | output | 21 | Address of the last decoded command |
| burst_len_o | output | 4 | Burst length in beats (2, 4 or 8) |
| rd_lat_cfg_o | output | 3 | Read-latency configuration code |
| imp_match_en_o | output | 1 | Output impedance-match enable |
| odt_en_o | output | 1 | On-die-termination enable |

## Verification
A wrong decode state shows up one cycle after the sampling edge as a missing, extra or wrong strobe, or as bank or address outputs that moved on a deselected cycle. Mode-register corruption is visible at once on the configuration outputs, and it persists, so a bad load or a spurious change is still there at every later check. The sweeps cover every combination of chip select and strobes across all banks. They also load every combination of burst code, latency code and the two enables, including the reserved burst code after each legal one.

// File: rtl/lldram_cmd_pkg.sv
package lldram_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_AREF  = 3'd3,
    CMD_MRS   = 3'd4
  } cmd_e;

  localparam int NUM_STB    = 4;
  localparam int MR_BL_LSB  = 0;
  localparam int MR_BL_W    = 2;
  localparam int MR_LAT_LSB = 2;
  localparam int MR_LAT_W   = 3;
  localparam int MR_IMP_BIT = 8;
  localparam int MR_ODT_BIT = 9;

  localparam logic [MR_BL_W-1:0] BL_CODE_2    = 2'b00;
  localparam logic [MR_BL_W-1:0] BL_CODE_RSVD = 2'b11;
endpackage

// File: rtl/lldram_cmd_decode.sv
module lldram_cmd_decode
  import lldram_cmd_pkg::*;
(
  input  logic cs_ni,
  input  logic we_ni,
  input  logic ref_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_ni) begin
      cmd_o = CMD_NONE;
    end else begin
      unique case ({we_ni, ref_ni})
        2'b11:   cmd_o = CMD_READ;
        2'b01:   cmd_o = CMD_WRITE;
        2'b10:   cmd_o = CMD_AREF;
        default: cmd_o = CMD_MRS;
      endcase
    end
  end
endmodule

// File: rtl/lldram_cmd_issue.sv
module lldram_cmd_issue
  import lldram_cmd_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [NUM_STB-1:0] stb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] bank_o
);
  logic [NUM_STB-1:0] stb_d;

  // strobe k is asserted for command code k+1
  for (genvar k = 0; k < NUM_STB; k++) begin : g_stb
    assign stb_d[k] = (cmd_i == cmd_e'(3'(k + 1)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_o  <= '0;
      addr_o <= '0;
      bank_o <= '0;
    end else begin
      stb_o <= stb_d;
      if (cmd_i != CMD_NONE) begin
        addr_o <= addr_i;
        bank_o <= bank_i;
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_o)); // R3
  AST_IDLE_HOLDS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_NONE) |=> ($stable(addr_o) && $stable(bank_o))); // R2
  AST_STROBE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_NONE) |=> (stb_o == '0)); // R10
  AST_ADDR_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_NONE) |=> (addr_o == $past(addr_i) && bank_o == $past(bank_i))); // R4
endmodule

// File: rtl/lldram_mode_reg.sv
module lldram_mode_reg
  import lldram_cmd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [MR_BL_W-1:0]  bl_code_i,
  input  logic [MR_LAT_W-1:0] lat_i,
  input  logic                imp_i,
  input  logic                odt_i,
  output logic [3:0]          burst_len_o,
  output logic [MR_LAT_W-1:0] rd_lat_o,
  output logic                imp_en_o,
  output logic                odt_en_o
);
  logic [MR_BL_W-1:0] bl_code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bl_code_q <= BL_CODE_2;
      rd_lat_o  <= '0;
      imp_en_o  <= 1'b0;
      odt_en_o  <= 1'b0;
    end else if (load_i) begin
      if (bl_code_i != BL_CODE_RSVD) bl_code_q <= bl_code_i;
      rd_lat_o <= lat_i;
      imp_en_o <= imp_i;
      odt_en_o <= odt_i;
    end
  end

  // beats = 2 << code
  assign burst_len_o = 4'd2 << bl_code_q;

  AST_BL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_len_o == 4'd2 || burst_len_o == 4'd4 || burst_len_o == 4'd8)); // R5
  AST_RSVD_KEEPS_BL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && bl_code_i == BL_CODE_RSVD) |=> $stable(burst_len_o)); // R6
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(burst_len_o) && $stable(rd_lat_o) && $stable(imp_en_o)
                 && $stable(odt_en_o))); // R9
  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (rd_lat_o == $past(lat_i) && imp_en_o == $past(imp_i)
                && odt_en_o == $past(odt_i))); // R7
endmodule

// File: rtl/lldram_cmd_frontend.sv
module lldram_cmd_frontend
  import lldram_cmd_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              ref_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic              aref_o,
  output logic              mrs_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [3:0]        burst_len_o,
  output logic [MR_LAT_W-1:0] rd_lat_cfg_o,
  output logic              imp_match_en_o,
  output logic              odt_en_o
);
  cmd_e               cmd;
  logic [NUM_STB-1:0] stb;

  lldram_cmd_decode u_decode (
    .cs_ni  (cs_ni),
    .we_ni  (we_ni),
    .ref_ni (ref_ni),
    .cmd_o  (cmd)
  );

  lldram_cmd_issue #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
  ) u_issue (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd),
    .addr_i (addr_i),
    .bank_i (bank_i),
    .stb_o  (stb),
    .addr_o (addr_o),
    .bank_o (bank_o)
  );

  assign rd_o   = stb[0];
  assign wr_o   = stb[1];
  assign aref_o = stb[2];
  assign mrs_o  = stb[3];

  lldram_mode_reg u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cmd == CMD_MRS),
    .bl_code_i   (addr_i[MR_BL_LSB +: MR_BL_W]),
    .lat_i       (addr_i[MR_LAT_LSB +: MR_LAT_W]),
    .imp_i       (addr_i[MR_IMP_BIT]),
    .odt_i       (addr_i[MR_ODT_BIT]),
    .burst_len_o (burst_len_o),
    .rd_lat_o    (rd_lat_cfg_o),
    .imp_en_o    (imp_match_en_o),
    .odt_en_o    (odt_en_o)
  );

  AST_DESELECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !(rd_o || wr_o || aref_o || mrs_o)); // R2
  AST_MRS_PAIRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !we_ni && !ref_ni) |=> mrs_o); // R3
  AST_TERM_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs_o |-> (odt_en_o == $past(addr_i[MR_ODT_BIT])
               && imp_match_en_o == $past(addr_i[MR_IMP_BIT]))); // R8
endmodule

// File: tb/tb_lldram_cmd_frontend.sv
module tb_lldram_cmd_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 21;
  localparam int BANK_W = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, we_ni = 1'b1, ref_ni = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [BANK_W-1:0] bank_i = '0;
  logic rd_o, wr_o, aref_o, mrs_o, imp_match_en_o, odt_en_o;
  logic [BANK_W-1:0] bank_o;
  logic [ADDR_W-1:0] addr_o;
  logic [3:0] burst_len_o;
  logic [2:0] rd_lat_cfg_o;

  int checks = 0;
  int errors = 0;

  logic [3:0] e_strb;
  logic [BANK_W-1:0] e_bank = '0;
  logic [ADDR_W-1:0] e_addr = '0;
  logic [3:0] e_bl = 4'd2;
  logic [2:0] e_lat = '0;
  logic e_imp = 1'b0, e_odt = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lldram_cmd_frontend dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .we_ni(we_ni), .ref_ni(ref_ni),
    .addr_i(addr_i), .bank_i(bank_i), .rd_o(rd_o), .wr_o(wr_o), .aref_o(aref_o),
    .mrs_o(mrs_o), .bank_o(bank_o), .addr_o(addr_o), .burst_len_o(burst_len_o),
    .rd_lat_cfg_o(rd_lat_cfg_o), .imp_match_en_o(imp_match_en_o), .odt_en_o(odt_en_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string req_s, input string req_c);
    check({req_s, " strobes {mrs,aref,wr,rd}"}, {28'd0, mrs_o, aref_o, wr_o, rd_o}, {28'd0, e_strb});
    check({req_s, " bank_o"}, 32'(bank_o), 32'(e_bank));
    check({req_s, " addr_o"}, 32'(addr_o), 32'(e_addr));
    check({req_c, " burst_len_o"}, 32'(burst_len_o), 32'(e_bl));
    check({req_c, " rd_lat_cfg_o"}, 32'(rd_lat_cfg_o), 32'(e_lat));
    check({req_c, " imp_match_en_o"}, 32'(imp_match_en_o), 32'(e_imp));
    check({req_c, " odt_en_o"}, 32'(odt_en_o), 32'(e_odt));
  endtask

  // Drive at a falling edge, sample at the next falling edge.
  task automatic issue(input logic cs, input logic we, input logic rf,
                       input logic [ADDR_W-1:0] a, input logic [BANK_W-1:0] b,
                       input string req_s, input string req_c);
    cs_ni = cs; we_ni = we; ref_ni = rf; addr_i = a; bank_i = b;
    @(posedge clk);
    @(negedge clk);
    e_strb = 4'b0000;
    if (!cs) begin
      case ({we, rf})
        2'b11:   e_strb = 4'b0001;
        2'b01:   e_strb = 4'b0010;
        2'b10:   e_strb = 4'b0100;
        default: e_strb = 4'b1000;
      endcase
      e_bank = b;
      e_addr = a;
      if (!we && !rf) begin
        if (a[1:0] != 2'b11) e_bl = 4'd2 << a[1:0];
        e_lat = a[4:2];
        e_imp = a[8];
        e_odt = a[9];
      end
    end
    check_all(req_s, req_c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    e_strb = 4'b0000;
    repeat (3) @(negedge clk);
    check_all("R1", "R1");            // in reset
    rst_ni = 1'b1;
    @(negedge clk);
    check_all("R1", "R1");            // after release, idle

    // R2 R3 R4 R9 R10: all strobe combinations on every bank, several addresses
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 8; b++) begin
        for (int c = 0; c < 8; c++) begin
          logic [ADDR_W-1:0] a;
          a = ADDR_W'((k * 32'h1A5F3 + b * 32'h2C1 + c * 32'h3B) & 32'h1FFFFF);
          issue(c[2], c[1], c[0], a, BANK_W'(b),
                c[2] ? "R2" : "R3/R4/R10", c[2] ? "R2" : "R9");
        end
      end
    end

    // R5 R6 R7 R8: every burst, latency, impedance and termination setting
    for (int m = 0; m < 128; m++) begin
      logic [ADDR_W-1:0] a;
      a = '0;
      a[1:0] = m[1:0];
      a[4:2] = m[4:2];
      a[8]   = m[5];
      a[9]   = m[6];
      a[20:10] = 11'(m * 7);
      issue(1'b0, 1'b0, 1'b0, a, BANK_W'(m), "R3/R4",
            (m[1:0] == 2'b11) ? "R6" : "R5/R7/R8");
      // non-MRS command must not disturb the mode register (R9)
      issue(1'b0, m[0], ~m[0], ~a, BANK_W'(m + 1), "R3/R4", "R9");
    end

    // R10: back-to-back identical reads keep strobe high, then idle drops it
    issue(1'b0, 1'b1, 1'b1, 21'h0ABCDE, 3'd5, "R10", "R9");
    issue(1'b0, 1'b1, 1'b1, 21'h154321, 3'd2, "R10", "R9");
    issue(1'b1, 1'b0, 1'b0, 21'h1FFFFF, 3'd7, "R10", "R2");

    // R6: reserved code right after each legal code
    for (int l = 0; l < 3; l++) begin
      issue(1'b0, 1'b0, 1'b0, ADDR_W'(l), 3'd0, "R3", "R5");
      issue(1'b0, 1'b0, 1'b0, ADDR_W'(32'h31F), 3'd1, "R3", "R6");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule